// File: doc/BRIEF.md
# Latched Interrupt Event Register

This block holds the interrupt event word of a serial-bus link controller, together with its companion mask word. Event pulses from the link, the PHY interface and the asynchronous DMA contexts land in sticky bits that stay at one until software clears them. Software reaches both words through a small register port. A write to a set address turns on every bit written as one. A write to a clear address turns off every bit written as one. Bits written as zero are left alone in both cases.

Two event bits are not stored. Bit 7 shows, in the same cycle, whether any isochronous receive context has an event that its per-context mask enables. Bit 6 shows the same for the isochronous transmit contexts. The bus-reset bit and the two self-ID-done bits follow their own rules. The block also offers a read view of the events that the mask enables, and a single interrupt line gated by a master enable in mask bit 31.

Top module: `irq_evt_reg`

## Requirements
- R1: Event bits 31..23 and 14..10 always read as 0 at read address 0, whatever hardware pulses or writes they receive.
- R2: A one on `hw_evt[b]` for a sticky bit b (22..15, 9, 8, 5..0) makes bit b read 1 from the next clock edge. The bit keeps that value until software clears it.
- R3: A write with `wr_addr`=0 sets every sticky event bit whose data bit is 1. Data bits at 0 change nothing.
- R4: A write with `wr_addr`=1 clears every sticky event bit whose data bit is 1. Data bits at 0 change nothing.
- R5: When a hardware pulse and a software clear reach the same sticky bit on the same edge, the bit ends up set.
- R6: Event bit 7 equals the OR over all contexts of `iso_rx_evt & iso_rx_msk`, and bit 6 the same for `iso_tx_evt & iso_tx_msk`. Both change in the cycle their inputs change, and set or clear writes do not affect them.
- R7: Any set of bus-reset bit 17, from hardware or software, clears self-ID-done bit 16 on the same edge. This holds even if bit 16 is set on that edge.
- R8: Every edge that sets bit 16 also sets secondary self-ID-done bit 15. Bit 15 is not affected by a set of bit 17.
- R9: The mask word is set by writes to `wr_addr`=2 and cleared by writes to `wr_addr`=3, one bit per data one. It reads back at `rd_addr`=2. Only bits 31, 22..15, 9..5 and 5..0 are kept, and all other mask bits read 0.
- R10: `rd_addr`=1 returns the event word ANDed with the mask word, with bit 31 forced to 0. `rd_addr`=3 returns 0.
- R11: `irq_o` is 1 exactly when mask bit 31 is 1 and at least one bit of the masked view at `rd_addr`=1 is 1.
- R12: After reset the event word, the mask word and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_evt | input | 32 | One-cycle event pulses, one per event bit position |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | 0 event set, 1 event clear, 2 mask set, 3 mask clear |
| wr_data | input | 32 | Write data; ones select bits |
| rd_addr | input | 2 | 0 event, 1 masked event, 2 mask, 3 zero |
| rd_data | output | 32 | Combinational read data |
| iso_rx_evt | input | ISO_CTX | Isochronous receive context events |
| iso_rx_msk | input | ISO_CTX | Isochronous receive context masks |
| iso_tx_evt | input | ISO_CTX | Isochronous transmit context events |
| iso_tx_msk | input | ISO_CTX | Isochronous transmit context masks |
| irq_o | output | 1 | Interrupt request |

## Verification
Stored bits, including the bus-reset and self-ID rules, change on the first clock edge after the pulse or write that causes them. Read data, bits 7 and 6 and `irq_o` follow the stored words and the isochronous inputs combinationally. The bench therefore drives its stimulus for exactly one edge and moves its reference model forward on that same edge. It then compares every read address and the interrupt line at the falling edge that follows. Live bits are checked by changing the context vectors away from any edge and comparing a nanosecond later.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;

    localparam int REG_W = 32;

    localparam int BIT_MASTER    = 31;
    localparam int BIT_BUS_RESET = 17;
    localparam int BIT_SID_DONE  = 16;
    localparam int BIT_SID_DONE2 = 15;
    localparam int BIT_ISO_RX    = 7;
    localparam int BIT_ISO_TX    = 6;

    // latched event bits: 22..15, 9, 8, 5..0
    localparam logic [REG_W-1:0] STICKY_BITS = 32'h007F_833F;
    // live summary bits: 7, 6
    localparam logic [REG_W-1:0] LIVE_BITS   = 32'h0000_00C0;
    localparam logic [REG_W-1:0] MASK_BITS   = STICKY_BITS | LIVE_BITS | (32'h1 << BIT_MASTER);

    typedef enum logic [1:0] {
        WA_EV_SET = 2'd0,
        WA_EV_CLR = 2'd1,
        WA_MK_SET = 2'd2,
        WA_MK_CLR = 2'd3
    } wr_addr_e;

    typedef enum logic [1:0] {
        RA_EVENT  = 2'd0,
        RA_MASKED = 2'd1,
        RA_MASK   = 2'd2,
        RA_ZERO   = 2'd3
    } rd_addr_e;

endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
    parameter int             W    = 32,
    parameter logic [W-1:0]   IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_v,
    input  logic [W-1:0] clr_v,
    output logic [W-1:0] q
);

    logic unused_inputs;
    assign unused_inputs = ^((set_v | clr_v) & ~IMPL);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_ff
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        bit_q <= 1'b0;
                else if (set_v[i]) bit_q <= 1'b1;
                else if (clr_v[i]) bit_q <= 1'b0;
            end
            assign q[i] = bit_q;
        end else begin : g_tie
            assign q[i] = 1'b0;
        end
    end

    // set beats clear on the same edge
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_v & IMPL)) |=> ((q & $past(set_v & IMPL)) == $past(set_v & IMPL)));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_v & ~set_v & IMPL)) |=> ((q & $past(clr_v & ~set_v & IMPL)) == '0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (((set_v | clr_v) & IMPL) == '0) |=> $stable(q));

endmodule

// File: rtl/irq_iso_summary.sv
module irq_iso_summary #(
    parameter int N = 8
) (
    input  logic [N-1:0] rx_evt,
    input  logic [N-1:0] rx_msk,
    input  logic [N-1:0] tx_evt,
    input  logic [N-1:0] tx_msk,
    output logic         rx_any,
    output logic         tx_any
);

    logic [N:0] rx_chain;
    logic [N:0] tx_chain;

    assign rx_chain[0] = 1'b0;
    assign tx_chain[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_ctx
        assign rx_chain[i+1] = rx_chain[i] | (rx_evt[i] & rx_msk[i]);
        assign tx_chain[i+1] = tx_chain[i] | (tx_evt[i] & tx_msk[i]);
    end

    assign rx_any = rx_chain[N];
    assign tx_any = tx_chain[N];

endmodule

// File: rtl/irq_evt_reg.sv
module irq_evt_reg
    import irq_evt_pkg::*;
#(
    parameter int ISO_CTX = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_W-1:0]   hw_evt,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [1:0]         rd_addr,
    output logic [REG_W-1:0]   rd_data,
    input  logic [ISO_CTX-1:0] iso_rx_evt,
    input  logic [ISO_CTX-1:0] iso_rx_msk,
    input  logic [ISO_CTX-1:0] iso_tx_evt,
    input  logic [ISO_CTX-1:0] iso_tx_msk,
    output logic               irq_o
);

    logic [REG_W-1:0] sw_ev_set, sw_ev_clr, sw_mk_set, sw_mk_clr;
    logic [REG_W-1:0] ev_src, ev_set, ev_clr;
    logic [REG_W-1:0] ev_q, mk_q, ev_view, masked;
    logic             bus_rst_hit;
    logic             rx_any, tx_any;

    // write decode
    always_comb begin
        sw_ev_set = '0;
        sw_ev_clr = '0;
        sw_mk_set = '0;
        sw_mk_clr = '0;
        if (wr_en) begin
            unique case (wr_addr_e'(wr_addr))
                WA_EV_SET: sw_ev_set = wr_data;
                WA_EV_CLR: sw_ev_clr = wr_data;
                WA_MK_SET: sw_mk_set = wr_data;
                WA_MK_CLR: sw_mk_clr = wr_data;
            endcase
        end
    end

    // cross-bit rules for bus reset and self-ID completion
    always_comb begin
        ev_src      = (hw_evt | sw_ev_set) & STICKY_BITS;
        bus_rst_hit = ev_src[BIT_BUS_RESET];
        ev_set      = ev_src;
        ev_set[BIT_SID_DONE]  = ev_src[BIT_SID_DONE] & ~bus_rst_hit;
        ev_set[BIT_SID_DONE2] = ev_src[BIT_SID_DONE2] | ev_set[BIT_SID_DONE];
        ev_clr      = sw_ev_clr & STICKY_BITS;
        ev_clr[BIT_SID_DONE]  = ev_clr[BIT_SID_DONE] | bus_rst_hit;
    end

    irq_sticky_bank #(.W(REG_W), .IMPL(STICKY_BITS)) u_event (
        .clk   (clk),
        .rst_n (rst_n),
        .set_v (ev_set),
        .clr_v (ev_clr),
        .q     (ev_q)
    );

    irq_sticky_bank #(.W(REG_W), .IMPL(MASK_BITS)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .set_v (sw_mk_set),
        .clr_v (sw_mk_clr),
        .q     (mk_q)
    );

    irq_iso_summary #(.N(ISO_CTX)) u_iso (
        .rx_evt (iso_rx_evt),
        .rx_msk (iso_rx_msk),
        .tx_evt (iso_tx_evt),
        .tx_msk (iso_tx_msk),
        .rx_any (rx_any),
        .tx_any (tx_any)
    );

    always_comb begin
        ev_view             = ev_q;
        ev_view[BIT_ISO_RX] = rx_any;
        ev_view[BIT_ISO_TX] = tx_any;
        masked              = ev_view & mk_q;
        masked[BIT_MASTER]  = 1'b0;
    end

    assign irq_o = mk_q[BIT_MASTER] & (|masked);

    always_comb begin
        unique case (rd_addr_e'(rd_addr))
            RA_EVENT:  rd_data = ev_view;
            RA_MASKED: rd_data = masked;
            RA_MASK:   rd_data = mk_q;
            RA_ZERO:   rd_data = '0;
        endcase
    end

    assert_bus_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_hit |=> !ev_q[BIT_SID_DONE]);

    assert_sid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev_q[BIT_SID_DONE]) |-> ev_q[BIT_SID_DONE2]);

    assert_sid2_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_q[BIT_SID_DONE2] && !ev_clr[BIT_SID_DONE2]) |=> ev_q[BIT_SID_DONE2]);

    assert_master_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !mk_q[BIT_MASTER] |-> !irq_o);

endmodule

// File: tb/test_irq_evt_reg.sv
module test_irq_evt_reg;

    localparam int NC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   hw_evt = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [1:0]    rd_addr = '0;
    logic [31:0]   rd_data;
    logic [NC-1:0] iso_rx_evt = '0, iso_rx_msk = '0, iso_tx_evt = '0, iso_tx_msk = '0;
    logic          irq_o;

    int checks = 0;
    int errors = 0;
    bit [31:0] m_ev = '0;
    bit [31:0] m_mk = '0;

    always #10 clk = ~clk;

    irq_evt_reg #(.ISO_CTX(NC)) i_irq_evt_reg (
        .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .iso_rx_evt(iso_rx_evt), .iso_rx_msk(iso_rx_msk),
        .iso_tx_evt(iso_tx_evt), .iso_tx_msk(iso_tx_msk), .irq_o(irq_o)
    );

    function automatic bit latched(int b);
        return (b >= 15 && b <= 22) || b == 8 || b == 9 || b <= 5;
    endfunction

    function automatic bit maskable(int b);
        return latched(b) || b == 6 || b == 7 || b == 31;
    endfunction

    function automatic bit [31:0] view();
        bit [31:0] v = m_ev;
        v[7] = |(iso_rx_evt & iso_rx_msk);
        v[6] = |(iso_tx_evt & iso_tx_msk);
        return v;
    endfunction

    function automatic bit [31:0] masked_view();
        bit [31:0] v = view() & m_mk;
        v[31] = 1'b0;
        return v;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        for (int ra = 0; ra < 4; ra++) begin
            bit [31:0] e;
            rd_addr = 2'(ra);
            #1;
            case (ra)
                0: e = view();
                1: e = masked_view();
                2: e = m_mk;
                default: e = '0;
            endcase
            check(tag, rd_data, e);
        end
        check({tag, " irq"}, {31'd0, irq_o}, {31'd0, m_mk[31] && (masked_view() != 0)});
    endtask

    // one clock edge; the model moves on the same edge
    task automatic step();
        bit [31:0] ne = m_ev, nm = m_mk;
        bit [31:0] sset = (wr_en && wr_addr == 2'd0) ? wr_data : '0;
        bit [31:0] sclr = (wr_en && wr_addr == 2'd1) ? wr_data : '0;
        bit br  = hw_evt[17] | sset[17];
        bit sid = (hw_evt[16] | sset[16]) & ~br;
        for (int b = 0; b < 32; b++) begin
            bit s;
            if (!latched(b)) continue;
            s = hw_evt[b] | sset[b];
            if (b == 16) s = sid;
            if (b == 15) s = s | sid;
            if (b == 16 && br) ne[b] = 1'b0;
            else if (s)        ne[b] = 1'b1;
            else if (sclr[b])  ne[b] = 1'b0;
        end
        for (int b = 0; b < 32; b++) begin
            if (!maskable(b) || !wr_en) continue;
            if (wr_addr == 2'd2 && wr_data[b]) nm[b] = 1'b1;
            if (wr_addr == 2'd3 && wr_data[b]) nm[b] = 1'b0;
        end
        @(posedge clk);
        m_ev = ne;
        m_mk = nm;
        @(negedge clk);
        hw_evt = '0;
        wr_en  = 1'b0;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d, string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        check_all(tag);
    endtask

    task automatic pulse(logic [31:0] p, string tag);
        hw_evt = p;
        step();
        check_all(tag);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all("R12 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R12 after release");

        // R2: individual hardware pulses
        pulse(32'h0000_0001, "R2");
        pulse(32'h0040_0000, "R2");
        check("R2 bit22 held", rd_data, 32'h0); // rd_addr is 3 after check_all
        rd_addr = 2'd0; #1;
        check("R2 sticky", rd_data & 32'h0040_0001, 32'h0040_0001);
        pulse(32'h0, "R2 hold");

        // R1: reserved bits ignore pulses and writes
        pulse(32'hFF80_7C00, "R1 hw");
        wr(2'd0, 32'hFF80_7C00, "R1 sw");
        rd_addr = 2'd0; #1;
        check("R1 reserved", rd_data & 32'hFF80_7C00, 32'h0);

        // R3 / R4
        wr(2'd0, 32'h0000_0330, "R3 set");
        wr(2'd0, 32'h0, "R3 zero write");
        wr(2'd1, 32'h0000_0021, "R4 clear");
        wr(2'd1, 32'h0, "R4 zero write");
        wr(2'd1, 32'hFFFF_FFFF, "R4 clear all");
        rd_addr = 2'd0; #1;
        check("R4 empty", rd_data, 32'h0);

        // R5: collision
        hw_evt = 32'h0000_0204; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h0000_0206;
        step();
        check_all("R5 collide");
        rd_addr = 2'd0; #1;
        check("R5 set wins", rd_data & 32'h0000_0206, 32'h0000_0204);

        // R6: live summary bits
        iso_rx_evt = 8'h10; iso_rx_msk = 8'h01; #1;
        check_all("R6 rx unmasked");
        iso_rx_msk = 8'h11; #1;
        check_all("R6 rx");
        iso_tx_evt = 8'h80; iso_tx_msk = 8'h80; #1;
        rd_addr = 2'd0; #1;
        check("R6 both", rd_data & 32'hC0, 32'hC0);
        wr(2'd1, 32'h0000_00C0, "R6 clear ignored");
        iso_rx_evt = 8'h00; #1;
        check_all("R6 rx drop");
        wr(2'd0, 32'h0000_0080, "R6 set ignored");
        iso_tx_evt = 8'h00; #1;
        check_all("R6 idle");

        // R7 / R8
        pulse(32'h0001_0000, "R8 sid");
        rd_addr = 2'd0; #1;
        check("R8 sid2", rd_data & 32'h0001_8000, 32'h0001_8000);
        pulse(32'h0002_0000, "R7 bus reset");
        rd_addr = 2'd0; #1;
        check("R7 sid cleared", rd_data & 32'h0003_8000, 32'h0002_8000);
        wr(2'd1, 32'h0003_8000, "R8 clear");
        pulse(32'h0003_0000, "R7 same edge");
        rd_addr = 2'd0; #1;
        check("R7 override", rd_data & 32'h0003_8000, 32'h0002_0000);
        wr(2'd0, 32'h0001_0000, "R8 sw sid");
        wr(2'd0, 32'h0002_0000, "R7 sw bus reset");

        // R9 / R10 / R11
        wr(2'd2, 32'hFFFF_FFFF, "R9 mask set");
        rd_addr = 2'd2; #1;
        check("R9 implemented", rd_data, 32'hFF7F_83FF & 32'h807F_83FF);
        wr(2'd3, 32'h8000_0000, "R11 master off");
        check("R11 gated", {31'd0, irq_o}, 32'h0);
        wr(2'd2, 32'h8000_0000, "R11 master on");
        wr(2'd3, 32'h007F_833F, "R10 mask live only");
        iso_tx_evt = 8'h02; iso_tx_msk = 8'h02; #1;
        check_all("R11 live irq");
        iso_tx_msk = 8'h00; #1;
        check_all("R10 masked");
        wr(2'd3, 32'hFFFF_FFFF, "R9 mask clear");

        // random mix across all rules
        for (int n = 0; n < 400; n++) begin
            hw_evt     = $urandom & $urandom & $urandom;
            wr_en      = 1'($urandom);
            wr_addr    = 2'($urandom);
            wr_data    = $urandom;
            iso_rx_evt = NC'($urandom); iso_rx_msk = NC'($urandom);
            iso_tx_evt = NC'($urandom); iso_tx_msk = NC'($urandom);
            step();
            check_all("R10 random mix");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule